// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This core runs programs of 8-bit instructions on 4-bit data. It keeps four 4-bit working registers, an 8-bit program counter and a 4-bit page register. The page register supplies the upper half of every data-memory address. Instruction memory and data memory are separate and both live outside the core. Each memory has 256 entries and a synchronous read: an address sampled at a clock edge returns its word in the next cycle. The core reads and writes the low 4 bits of each data word.

Every instruction takes one fetch cycle followed by one execute cycle. In the fetch cycle the program counter goes out as the instruction address, and a ripple add-one chain advances the counter. In the execute cycle the returned instruction is decoded. Data-path operations go to a separate ALU instance as a 3-bit operation code. Conditional branches test register r0 with an equal-to-zero detector and a positive detector. A load result arrives during the following fetch cycle and is written then, so the very next instruction can read it.

Top module: `nib_cpu_core`

## Requirements
- R1: While rst_ni is low, the program counter, all four registers and the page register are cleared. After release, the first fetch is at address 0x00.
- R2: Each instruction takes exactly two cycles. imem_addr_o holds the program counter. At the end of each fetch cycle it rises by one, wrapping from 0xFF to 0x00. Between fetches it changes only through a taken branch.
- R3: Bits [7:4] are the opcode, bits [3:2] select rd and bits [1:0] select rs. The opcodes are 0x1 rd+rs, 0x2 rd-rs, 0x3 rd&rs, 0x4 rd|rs, 0x5 rd^rs, 0x6 ~rs, 0x7 rd shifted left by rs[1:0] and 0x8 copy rs. Each result is written to rd, modulo 16.
- R4: Opcode 0x9 writes the 4-bit literal in bits [3:0] into r0.
- R5: Opcode 0xA writes the literal in bits [3:0] into the page register. No other opcode changes the page register.
- R6: Opcode 0xB loads rd from the low nibble of data memory at {page, value of rs}. The next instruction already reads the loaded value.
- R7: Opcode 0xC writes the value of rd to data memory at {page, value of rs}. dmem_we_o is high only in the execute cycle of this opcode.
- R8: Opcode 0xD branches when r0 equals zero. The next fetch address is then the branch's own address + 1 + the sign-extended offset in bits [3:0]. Otherwise execution falls through.
- R9: Opcode 0xE branches in the same way when r0 is positive, that is, bit 3 is clear and some other bit is set. A value of 0 or 8..15 falls through.
- R10: Opcode 0xF always branches relative, as in R8. Opcode 0x0 changes no register, no page and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction memory address (program counter) |
| imem_rdata_i | input | 8 | Instruction word returned one cycle after its address |
| dmem_addr_o | output | 8 | Data memory address {page, rs value} |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_wdata_o | output | 4 | Data memory write nibble |
| dmem_rdata_i | input | 4 | Data memory read nibble, one cycle after its address |

## Verification
A load's register write-back and the fetch of the next instruction share one cycle. The two collide when the next instruction reads the register that was just loaded. The directed prefix provokes this by placing a load directly before a store of the same register. The random program provokes it again whenever a load is followed by any reader. An instruction-level reference model in the bench judges every fetch address and every store's address and data, so a write-back that came late or went to the wrong register shows up at the next store.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;
  localparam int unsigned DW   = 4;
  localparam int unsigned AW   = 8;
  localparam int unsigned IW   = 8;
  localparam int unsigned NREG = 4;
  localparam int unsigned RSW  = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_AND = 4'h3,
    OP_OR  = 4'h4, OP_XOR = 4'h5, OP_NOT = 4'h6, OP_SLL = 4'h7,
    OP_MOV = 4'h8, OP_LDI = 4'h9, OP_LPG = 4'hA, OP_LD  = 4'hB,
    OP_ST  = 4'hC, OP_BZ  = 4'hD, OP_BGZ = 4'hE, OP_BRA = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR   = 3'd3,
    ALU_XOR = 3'd4, ALU_NOT = 3'd5, ALU_SLL = 3'd6, ALU_PASS = 3'd7
  } alu_op_e;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;
endpackage

// File: rtl/nib_cpu_incr.sv
module nib_cpu_incr #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  logic [W:0] c;
  assign c[0] = 1'b1;  // fixed carry-in makes this +1
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign y_o[i]  = a_i[i] ^ c[i];
    assign c[i+1]  = ~(~a_i[i] | ~c[i]);
  end
endmodule

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned SHW = (W > 1) ? $clog2(W) : 1;

  logic         sub;
  logic [W-1:0] bx, g, p, sum;
  logic [W:0]   c;

  assign sub  = (op_i == ALU_SUB);
  assign bx   = sub ? ~b_i : b_i;
  assign c[0] = sub;

  // generate/propagate carry chain
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i]   = a_i[i] & bx[i];
    assign p[i]   = a_i[i] ^ bx[i];
    assign c[i+1] = g[i] | (p[i] & c[i]);
    assign sum[i] = p[i] ^ c[i];
  end

  logic [W-1:0] shl;
  always_comb begin
    shl = a_i;
    for (int s = 0; s < SHW; s++) begin
      if (b_i[s]) shl = shl << (1 << s);
    end
  end

  always_comb begin
    unique case (op_i)
      ALU_ADD, ALU_SUB: y_o = sum;
      ALU_AND:          y_o = a_i & b_i;
      ALU_OR:           y_o = a_i | b_i;
      ALU_XOR:          y_o = a_i ^ b_i;
      ALU_NOT:          y_o = ~b_i;
      ALU_SLL:          y_o = shl;
      default:          y_o = b_i;
    endcase
  end
endmodule

// File: rtl/nib_cpu_cond.sv
module nib_cpu_cond #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] v_i,
  output logic         eqz_o,
  output logic         gtz_o
);
  assign eqz_o = ~|v_i;
  // positive: sign clear and some magnitude bit set
  assign gtz_o = ~(v_i[W-1] | ~|v_i[W-2:0]);
endmodule

// File: rtl/nib_cpu_regfile.sv
module nib_cpu_regfile
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned N = NREG,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [SW-1:0] ra_i,
  input  logic [SW-1:0] rb_i,
  output logic [W-1:0]  a_o,
  output logic [W-1:0]  b_o,
  output logic [W-1:0]  r0_o
);
  logic [W-1:0] regs_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[i] <= '0;
      else if (we_i && waddr_i == SW'(i))      regs_q[i] <= wdata_i;
    end
  end

  assign a_o  = regs_q[ra_i];
  assign b_o  = regs_q[rb_i];
  assign r0_o = regs_q[0];
endmodule

// File: rtl/nib_cpu_core.sv
module nib_cpu_core
  import nib_cpu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_rdata_i,
  output logic [AW-1:0] dmem_addr_o,
  output logic          dmem_we_o,
  output logic [DW-1:0] dmem_wdata_o,
  input  logic [DW-1:0] dmem_rdata_i
);
  localparam int unsigned PGW = AW - DW;

  phase_e          phase_q;
  logic [AW-1:0]   pc_q, pc_inc, pc_br;
  logic [PGW-1:0]  page_q;
  logic            ld_pend_q;
  logic [RSW-1:0]  ld_dst_q;

  opcode_e         opcode;
  logic [RSW-1:0]  rd_sel, rs_sel;
  logic [DW-1:0]   imm, rd_val, rs_val, r0_val, alu_y;
  logic            exec, is_alu, eqz, gtz, taken;
  alu_op_e         alu_op;
  logic [2:0]      alu_code;

  logic            rf_we;
  logic [RSW-1:0]  rf_waddr;
  logic [DW-1:0]   rf_wdata;

  assign exec   = (phase_q == PH_EXEC);
  assign opcode = opcode_e'(imem_rdata_i[IW-1:IW-4]);
  assign rd_sel = imem_rdata_i[2*RSW-1:RSW];
  assign rs_sel = imem_rdata_i[RSW-1:0];
  assign imm    = imem_rdata_i[DW-1:0];

  assign is_alu   = (opcode >= OP_ADD) && (opcode <= OP_MOV);
  assign alu_code = imem_rdata_i[IW-2:IW-4] - 3'd1;
  assign alu_op   = alu_op_e'(alu_code);

  nib_cpu_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .ra_i    (rd_sel),
    .rb_i    (rs_sel),
    .a_o     (rd_val),
    .b_o     (rs_val),
    .r0_o    (r0_val)
  );

  nib_cpu_alu #(.W(DW)) u_alu (
    .op_i (alu_op),
    .a_i  (rd_val),
    .b_i  (rs_val),
    .y_o  (alu_y)
  );

  nib_cpu_cond #(.W(DW)) u_cond (
    .v_i   (r0_val),
    .eqz_o (eqz),
    .gtz_o (gtz)
  );

  nib_cpu_incr #(.W(AW)) u_inc (
    .a_i (pc_q),
    .y_o (pc_inc)
  );

  // pc_q already points past the branch during execute
  assign pc_br = pc_q + {{PGW{imm[DW-1]}}, imm};

  always_comb begin
    unique case (opcode)
      OP_BZ:   taken = eqz;
      OP_BGZ:  taken = gtz;
      OP_BRA:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  // load write-back lands in the fetch cycle after the load
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rd_sel;
    rf_wdata = alu_y;
    if (!exec) begin
      rf_we    = ld_pend_q;
      rf_waddr = ld_dst_q;
      rf_wdata = dmem_rdata_i;
    end else if (is_alu) begin
      rf_we = 1'b1;
    end else if (opcode == OP_LDI) begin
      rf_we    = 1'b1;
      rf_waddr = '0;
      rf_wdata = imm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_FETCH;
      pc_q      <= '0;
      page_q    <= '0;
      ld_pend_q <= 1'b0;
      ld_dst_q  <= '0;
    end else if (!exec) begin
      phase_q   <= PH_EXEC;
      pc_q      <= pc_inc;
      ld_pend_q <= 1'b0;
    end else begin
      phase_q   <= PH_FETCH;
      if (taken)             pc_q   <= pc_br;
      if (opcode == OP_LPG)  page_q <= imm;
      ld_pend_q <= (opcode == OP_LD);
      ld_dst_q  <= rd_sel;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = {page_q, rs_val};
  assign dmem_wdata_o = rd_val;
  assign dmem_we_o    = exec && (opcode == OP_ST);

  // R2
  fetch_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FETCH |=> phase_q == PH_EXEC);
  // R2
  exec_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_EXEC |=> phase_q == PH_FETCH);
  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FETCH |=> imem_addr_o == $past(imem_addr_o) + 8'd1);
  // R7
  store_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> phase_q == PH_EXEC);
  // R5
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH || opcode != OP_LPG) |=> $stable(page_q));
  // R9
  cond_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eqz && gtz));
  // R10
  nop_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_NOP) |=> $stable(imem_addr_o));
  // R6
  load_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_LD) |=> ld_pend_q && phase_q == PH_FETCH);
endmodule

// File: tb/nib_cpu_core_test.sv
`timescale 1ns/1ps
module nib_cpu_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] imem_addr_o, imem_rdata_i, dmem_addr_o;
  logic       dmem_we_o;
  logic [3:0] dmem_wdata_o, dmem_rdata_i;

  always #2 clk_i = ~clk_i;  // 250 MHz

  nib_cpu_core uut (
    .clk_i, .rst_ni, .imem_addr_o, .imem_rdata_i,
    .dmem_addr_o, .dmem_we_o, .dmem_wdata_o, .dmem_rdata_i
  );

  logic [7:0] imem [256];
  logic [3:0] dmem [256];
  logic [3:0] mdm  [256];
  logic [3:0] mreg [4];
  logic [3:0] mpage;
  logic [7:0] mpc;
  string      reg_tag [4];
  string      page_tag, fetch_tag;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always @(posedge clk_i) begin
    if (dmem_we_o) dmem[dmem_addr_o] <= dmem_wdata_o;
    dmem_rdata_i <= dmem[dmem_addr_o];
    imem_rdata_i <= imem[imem_addr_o];
  end

  function automatic logic [3:0] alu_ref(logic [3:0] op, logic [3:0] a, logic [3:0] b);
    case (op)
      4'h1: return a + b;
      4'h2: return a - b;
      4'h3: return a & b;
      4'h4: return a | b;
      4'h5: return a ^ b;
      4'h6: return ~b;
      4'h7: return a << b[1:0];
      default: return b;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one instruction: fetch-phase check, execute-phase check, reference step
  task automatic step();
    logic [7:0] ins, pc1;
    logic [3:0] op, imm;
    logic [1:0] rd, rs;
    check(fetch_tag, "fetch address", imem_addr_o, mpc);
    @(negedge clk_i);
    ins = imem[mpc]; op = ins[7:4]; rd = ins[3:2]; rs = ins[1:0]; imm = ins[3:0];
    pc1 = mpc + 8'd1;
    if (op == 4'hC) begin
      check("R7", "store strobe", dmem_we_o, 1);
      check(page_tag, "store address", dmem_addr_o, {mpage, mreg[rs]});
      check(reg_tag[rd], "store data", dmem_wdata_o, mreg[rd]);
      mdm[{mpage, mreg[rs]}] = mreg[rd];
    end else begin
      check("R7", "no store strobe", dmem_we_o, 0);
    end
    fetch_tag = "R2";
    case (op)
      4'h0: fetch_tag = "R10";
      4'h9: begin mreg[0] = imm; reg_tag[0] = "R4"; end
      4'hA: begin mpage = imm; page_tag = "R5"; end
      4'hB: begin mreg[rd] = mdm[{mpage, mreg[rs]}]; reg_tag[rd] = "R6"; end
      4'hC: ;
      4'hD: begin fetch_tag = "R8"; if (mreg[0] == 0) pc1 = pc1 + {{4{imm[3]}}, imm}; end
      4'hE: begin fetch_tag = "R9";
                  if (!mreg[0][3] && mreg[0] != 0) pc1 = pc1 + {{4{imm[3]}}, imm}; end
      4'hF: begin fetch_tag = "R10"; pc1 = pc1 + {{4{imm[3]}}, imm}; end
      default: begin mreg[rd] = alu_ref(op, mreg[rd], mreg[rs]); reg_tag[rd] = "R3"; end
    endcase
    mpc = pc1;
    @(negedge clk_i);
  endtask

  initial begin
    logic [7:0] prefix [20];
    void'($urandom(32'd1998));
    for (int i = 0; i < 256; i++) begin
      imem[i] = 8'($urandom);
      dmem[i] = 4'($urandom);
      mdm[i]  = dmem[i];
    end
    prefix = '{8'hC5, 8'hCF, 8'h95, 8'h84, 8'h9A, 8'hE2, 8'hD2, 8'hA3,
               8'hC4, 8'hB8, 8'hC9, 8'h90, 8'hD1, 8'h9F, 8'h97, 8'hE1,
               8'h9F, 8'h0B, 8'h7D, 8'hCC};
    for (int i = 0; i < 20; i++) imem[i] = prefix[i];
    for (int i = 0; i < 4; i++) begin mreg[i] = 0; reg_tag[i] = "R1"; end
    mpage = 0; mpc = 0; page_tag = "R1"; fetch_tag = "R1";
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int s = 0; s < 4000; s++) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule